// File: doc/BRIEF.md
# Dual-Halfword Multiply-Subtract Accumulator

This block keeps one signed 64-bit running total and changes it by a pair of halfword products per operation. Each operand word carries two signed 16-bit lanes. The block multiplies the matching lanes of the two operands. It adds the product of the upper lanes to the total and takes away the product of the lower lanes. The result wraps modulo 2^64 and never saturates.

The total is reached as two separate 32-bit words, one high and one low. Both words can be written in one cycle through a load port. An operation takes two register stages:
- The lane products are captured on the edge that samples the start strobe.
- The total is updated on the next edge.
- A one-cycle done strobe is raised together with the new value.

A new operation can start on every cycle.

Top module: `dhms_mac_top`

## Requirements
- R1: While `rst` is high at a rising edge, the total is cleared to zero and `done_o` is low after that edge.
- R2: Bits [15:0] of each operand are the lower lane and bits [31:16] the upper lane. Each lane product is the full signed 32-bit product of the two matching halfwords. For example, 0x8000 times 0x8000 gives +2^30.
- R3: An accepted operation replaces the total T with T + sext64(upper product) − sext64(lower product). After the update, bits [63:32] appear on `acc_hi_o` and bits [31:0] on `acc_lo_o`.
- R4: A start sampled at edge n is accepted when `load_i` is low at that edge. Its result is visible after edge n+1, and `done_o` is high for exactly the cycle after edge n+1.
- R5: Starts on consecutive cycles are each accumulated in order, one per cycle, and each gives its own done pulse.
- R6: When `load_i` is high at an edge, `acc_hi_o` and `acc_lo_o` take `load_hi_i` and `load_lo_i` after that edge. A load raises no done pulse.
- R7: A start that is sampled together with a load is dropped. It never changes the total and never raises `done_o`.
- R8: A load on the edge where an earlier operation would update the total wins. The pending operation is discarded and gives no done pulse.
- R9: Accumulation wraps modulo 2^64. For example, 0x7FFFFFFF_FFFFFFFF plus 1 gives 0x80000000_00000000.
- R10: With no load and no pending operation, the total holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one multiply-accumulate operation |
| opa_i | input | 32 | First operand, two signed halfwords |
| opb_i | input | 32 | Second operand, two signed halfwords |
| load_i | input | 1 | Write the total directly |
| load_hi_i | input | 32 | Value for the high word on a load |
| load_lo_i | input | 32 | Value for the low word on a load |
| acc_hi_o | output | 32 | High word of the total |
| acc_lo_o | output | 32 | Low word of the total |
| done_o | output | 1 | One-cycle pulse when an operation's result is visible |

## Verification
An operation's result and its done pulse are due two edges after the start is driven. Edge one captures the products and edge two updates the total. A load is due one edge after it is driven. The bench drives inputs on falling edges and runs a behavioural model that advances on each rising edge. It compares both words and the done strobe on every falling edge, so each due time is checked in exactly the cycle it is due. The directed checks for the collision cases R7 and R8 are placed after the edge at which a wrong design would have raised done or changed the total.

// File: rtl/dhms_mac_pkg.sv
package dhms_mac_pkg;

    localparam int LANE_W    = 16;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;
    localparam int PROD_W    = 2 * LANE_W;
    localparam int ACC_W     = 2 * WORD_W;

    typedef logic [WORD_W-1:0]        word_t;
    typedef logic signed [LANE_W-1:0] lane_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_STEP = 2'd2
    } acc_op_e;

    typedef struct packed {
        logic    accept;
        logic    commit;
        acc_op_e op;
    } ctrl_t;

    function automatic lane_t lane_of(input word_t w, input int idx);
        return lane_t'(w[idx*LANE_W +: LANE_W]);
    endfunction

    function automatic acc_t widen(input prod_t p);
        return acc_t'(p);
    endfunction

    function automatic logic lane_adds(input int idx);
        return (idx % 2) == 1;
    endfunction

endpackage

// File: rtl/dhms_lane_mult.sv
module dhms_lane_mult
    import dhms_mac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  lane_t a,
    input  lane_t b,
    output prod_t prod_q
);
    prod_t prod_d;

    always_comb begin
        prod_d = prod_t'(a) * prod_t'(b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else if (en) begin
            prod_q <= prod_d;
        end
    end
endmodule

// File: rtl/dhms_combine.sv
module dhms_combine
    import dhms_mac_pkg::*;
(
    input  prod_t prods [NUM_LANES],
    output acc_t  delta
);
    acc_t terms [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_term
        if (lane_adds(g)) begin : g_add
            assign terms[g] = widen(prods[g]);
        end else begin : g_sub
            assign terms[g] = -widen(prods[g]);
        end
    end

    always_comb begin
        delta = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            delta = delta + terms[i];
        end
    end
endmodule

// File: rtl/dhms_acc_reg.sv
module dhms_acc_reg
    import dhms_mac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  acc_op_e op,
    input  word_t   ld_hi,
    input  word_t   ld_lo,
    input  acc_t    delta,
    output word_t   hi_q,
    output word_t   lo_q
);
    acc_t acc_q;
    acc_t acc_d;

    always_comb begin
        unique case (op)
            ACC_LOAD: acc_d = {ld_hi, ld_lo};
            ACC_STEP: acc_d = acc_q + delta;
            default:  acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign hi_q = acc_q[ACC_W-1:WORD_W];
    assign lo_q = acc_q[WORD_W-1:0];
endmodule

// File: rtl/dhms_mac_top.sv
module dhms_mac_top
    import dhms_mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic        load_i,
    input  logic [31:0] load_hi_i,
    input  logic [31:0] load_lo_i,
    output logic [31:0] acc_hi_o,
    output logic [31:0] acc_lo_o,
    output logic        done_o
);
    ctrl_t ctrl;
    logic  pend_q;
    logic  done_q;
    prod_t prods [NUM_LANES];
    acc_t  delta;

    always_comb begin
        ctrl.accept = start_i && !load_i;
        ctrl.commit = pend_q && !load_i;
        if (load_i) begin
            ctrl.op = ACC_LOAD;
        end else if (pend_q) begin
            ctrl.op = ACC_STEP;
        end else begin
            ctrl.op = ACC_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            pend_q <= ctrl.accept;
            done_q <= ctrl.commit;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dhms_lane_mult u_mult (
            .clk    (clk),
            .rst    (rst),
            .en     (ctrl.accept),
            .a      (lane_of(opa_i, g)),
            .b      (lane_of(opb_i, g)),
            .prod_q (prods[g])
        );
    end

    dhms_combine u_comb (
        .prods (prods),
        .delta (delta)
    );

    dhms_acc_reg u_acc (
        .clk   (clk),
        .rst   (rst),
        .op    (ctrl.op),
        .ld_hi (load_hi_i),
        .ld_lo (load_lo_i),
        .delta (delta),
        .hi_q  (acc_hi_o),
        .lo_q  (acc_lo_o)
    );

    assign done_o = done_q;
endmodule

// File: rtl/dhms_mac_chk.sv
module dhms_mac_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic        load_i,
    input logic [31:0] load_hi_i,
    input logic [31:0] load_lo_i,
    input logic [31:0] acc_hi_o,
    input logic [31:0] acc_lo_o,
    input logic        done_o
);
    function automatic logic [63:0] step_of(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] up;
        logic signed [63:0] dn;
        up = 64'($signed(a[31:16])) * 64'($signed(b[31:16]));
        dn = 64'($signed(a[15:0])) * 64'($signed(b[15:0]));
        return up - dn;
    endfunction

    // R4 R7 R8: done only for a start accepted two edges back, with no load since
    assert_done_source_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(start_i, 2) && !$past(load_i, 2) && !$past(load_i)));

    // R6: a load shows on the words one edge later
    assert_load_visible_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(load_i) && !$past(rst)) |->
        (acc_hi_o == $past(load_hi_i) && acc_lo_o == $past(load_lo_i) && !done_o));

    // R10: the total holds without a load or a completion
    assert_hold_total_R10: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(load_i) && !$past(rst)) |-> $stable({acc_hi_o, acc_lo_o}));

    // R3: a completion moves the total by upper product minus lower product
    assert_step_value_R3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(rst)) |->
        ({acc_hi_o, acc_lo_o} ==
         $past({acc_hi_o, acc_lo_o}) + step_of($past(opa_i, 2), $past(opb_i, 2))));
endmodule

bind dhms_mac_top dhms_mac_chk u_chk (.*);

// File: tb/test_dhms_mac_top.sv
`timescale 1ns/1ps
module test_dhms_mac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        load_i = 1'b0;
    logic [31:0] load_hi_i = '0;
    logic [31:0] load_lo_i = '0;
    logic [31:0] acc_hi_o;
    logic [31:0] acc_lo_o;
    logic        done_o;

    int    n_vec  = 0;
    int    n_bad  = 0;
    string tag    = "R1";
    bit    armed  = 0;
    bit    ended  = 0;

    logic [63:0] m_acc   = '0;
    logic [63:0] m_delta = '0;
    bit          m_pend  = 0;
    bit          m_done  = 0;

    always #5 clk = ~clk;

    dhms_mac_top i_dhms_mac_top (.*);

    function automatic logic [63:0] lane_step(input logic [31:0] a, input logic [31:0] b);
        longint up, dn;
        up = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
        dn = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        return 64'(up - dn);
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_acc = '0; m_pend = 0; m_done = 0;
        end else begin
            m_done = m_pend && !load_i;
            if (load_i) m_acc = {load_hi_i, load_lo_i};
            else if (m_pend) m_acc = m_acc + m_delta;
            m_pend = start_i && !load_i;
            if (m_pend) m_delta = lane_step(opa_i, opb_i);
        end
        armed = 1;
    end

    // full compare on every falling edge
    always @(negedge clk) begin
        if (armed && !ended) begin
            n_vec++;
            if ({acc_hi_o, acc_lo_o} !== m_acc || done_o !== m_done) begin
                n_bad++;
                $display("FAIL %s: acc=%h done=%b expected acc=%h done=%b",
                         tag, {acc_hi_o, acc_lo_o}, done_o, m_acc, m_done);
            end
        end
    end

    task automatic drive(input bit s, input logic [31:0] a, input logic [31:0] b,
                         input bit l, input logic [31:0] h, input logic [31:0] lo);
        start_i = s; opa_i = a; opb_i = b;
        load_i = l; load_hi_i = h; load_lo_i = lo;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(0, '0, '0, 0, '0, '0);
    endtask

    task automatic expect_state(input string t, input logic [63:0] e_acc, input bit e_done);
        n_vec++;
        if ({acc_hi_o, acc_lo_o} !== e_acc || done_o !== e_done) begin
            n_bad++;
            $display("FAIL %s: acc=%h done=%b expected acc=%h done=%b",
                     t, {acc_hi_o, acc_lo_o}, done_o, e_acc, e_done);
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        tag = "R1";
        expect_state("R1", 64'h0, 1'b0);
        rst = 1'b0;
        idle();
        expect_state("R1", 64'h0, 1'b0);

        // R3: +3*5 -2*7 = +1, visible two edges after start (R4)
        tag = "R4";
        drive(1, 32'h0003_0002, 32'h0005_0007, 0, '0, '0);
        expect_state("R4", 64'h0, 1'b0);
        idle();
        expect_state("R3", 64'h1, 1'b1);
        idle();
        expect_state("R4", 64'h1, 1'b0);

        // R2: signed extremes, +2^30 - (-32768*32767)
        tag = "R2";
        drive(1, 32'h8000_8000, 32'h8000_7FFF, 0, '0, '0);
        idle();
        expect_state("R2", 64'h1 + 64'h7FFF_8000, 1'b1);

        // R6: load, no done
        tag = "R6";
        drive(0, '0, '0, 1, 32'h1234_5678, 32'h9ABC_DEF0);
        expect_state("R6", 64'h1234_5678_9ABC_DEF0, 1'b0);
        idle();
        expect_state("R10", 64'h1234_5678_9ABC_DEF0, 1'b0);

        // R9: wrap across the sign boundary
        tag = "R9";
        drive(0, '0, '0, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        drive(1, 32'h0001_0000, 32'h0001_0000, 0, '0, '0);
        idle();
        expect_state("R9", 64'h8000_0000_0000_0000, 1'b1);
        drive(0, '0, '0, 1, 32'h0, 32'h0);
        drive(1, 32'h0000_0001, 32'h0000_0001, 0, '0, '0);
        idle();
        expect_state("R9", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);

        // R7: start together with load is dropped
        tag = "R7";
        drive(1, 32'h0100_0000, 32'h0100_0000, 1, 32'h0, 32'h55);
        expect_state("R7", 64'h55, 1'b0);
        idle();
        expect_state("R7", 64'h55, 1'b0);

        // R8: load on the commit edge wins
        tag = "R8";
        drive(1, 32'h0010_0000, 32'h0010_0000, 0, '0, '0);
        drive(0, '0, '0, 1, 32'h0, 32'h77);
        expect_state("R8", 64'h77, 1'b0);
        idle();
        expect_state("R8", 64'h77, 1'b0);

        // R5: back-to-back starts
        tag = "R5";
        drive(1, 32'h0002_0000, 32'h0003_0000, 0, '0, '0);
        drive(1, 32'h0000_0004, 32'h0000_0001, 0, '0, '0);
        expect_state("R5", 64'h77 + 64'd6, 1'b1);
        idle();
        expect_state("R5", 64'h77 + 64'd2, 1'b1);
        idle();

        // R5 R10: mixed traffic, checked against the model each cycle
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            drive(r < 6, $urandom, $urandom, r == 9, $urandom, $urandom);
        end
        repeat (3) idle();

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule